// File: doc/BRIEF.md
# Control/Status Register Bank with Atomic Wide Fields

This block is a small register bank placed on a simple processor bus. The bus has a word address, a write strobe, write data and registered read data. Behind that bus sit four kinds of storage. A configuration field is wider than a bus word and is written atomically. A control field is also wider than a bus word; the bus and the device can both write it, and bus writes take effect chunk by chunk. A status word is owned by the device and read by the bus. A raw port gives the device a strobe whenever the bus reads it.

A field wider than a bus word occupies consecutive word addresses. The lowest of those addresses carries the most significant part of the field, zero-padded at the top so that the remainder of the field starts on a word boundary. The last address carries the least significant word.

For the atomic field, writes to every word except the last are parked in shadow registers. The write to the last word moves the shadows and the new low word into the live value in one clock edge, so the device never observes a half-written configuration.

Top module: `csr_bank`

## Requirements
- R1: After reset the configuration field holds CFG_RST and the control field holds CTL_RST (defaults 20'hA5C3E and 12'h3C1). Both values are visible on the device outputs and through bus reads.
- R2: Word addresses are 0..2 for the configuration field, 3..4 for control, 5 for status and 6 for the raw port. Within a wide field, the lowest address returns the most significant bits, right-aligned, and the last address returns bits [7:0].
- R3: A bus write to configuration address 0 or 1 leaves the live configuration value, and hence dev_cfg_q, unchanged.
- R4: A bus write to configuration address 2 sets live bits [7:0] from the write data. On the same edge it loads bits [19:8] from the most recent shadow writes to addresses 1 (bits [15:8]) and 0 (bits [19:16] from its data [3:0]).
- R5: A bus write to a control address updates only that word's slice of dev_ctl_q on the next edge.
- R6: Padding bits above a field's top bit always read as zero, and writes to them are discarded.
- R7: When dev_ctl_we is high, dev_ctl_d is loaded into the control field. If the bus writes a control word in the same cycle, the bus data wins for that word's bits.
- R8: A bus read of address 5 returns dev_stat_d as it was in the address cycle, zero-extended. The status word has no storage.
- R9: dev_raw_rd is high in exactly those cycles where the address is 6 and the write strobe is low. The read returns dev_raw_d from that cycle, and a bus write to address 6 has no effect.
- R10: Reads from addresses 7 and above return zero, and writes to them change no field.
- R11: bus_rdata presents the data for the address of the previous cycle. There is one cycle of read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Registered read data |
| dev_cfg_q | output | CFG_W | Live configuration value |
| dev_ctl_q | output | CTL_W | Live control value |
| dev_ctl_we | input | 1 | Device write enable for control |
| dev_ctl_d | input | CTL_W | Device write data for control |
| dev_stat_d | input | STAT_W | Device status word |
| dev_raw_rd | output | 1 | Read strobe for the raw port |
| dev_raw_d | input | RAW_W | Device data returned on raw reads |

## Verification
Directed sequences write the three configuration words in order and read each word back. This separates the shadow hold from the commit, and the MSB-first layout from a reversed one. Padding-only patterns such as 0xFF to a top word show whether padding is masked. Collisions between device and bus writes on the control field distinguish bus priority from device priority. A long constrained-random stream of mixed reads and writes then runs over mapped and unmapped addresses, with random status, raw and device-write inputs. That stream catches stale shadows, wrong read latency and stray raw strobes against a bench model.

// File: rtl/csr_pkg.sv
package csr_pkg;

    // Address regions decoded by the bank
    typedef enum logic [2:0] {
        RG_CFG,
        RG_CTL,
        RG_STAT,
        RG_RAW,
        RG_NONE
    } region_e;

    // Number of bus words a field occupies once padded to a word boundary
    function automatic int num_chunks(input int field_w, input int word_w);
        return (field_w + word_w - 1) / word_w;
    endfunction

endpackage

// File: rtl/csr_wide_field.sv
module csr_wide_field #(
    parameter int FIELD_W   = 20,
    parameter int WORD_W    = 8,
    parameter int ADDR_W    = 4,
    parameter int BASE      = 0,
    parameter bit ATOMIC    = 1'b0,
    parameter bit DEV_WRITE = 1'b0,
    parameter logic [FIELD_W-1:0] RESET_VAL = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [WORD_W-1:0]  bus_wdata,
    input  logic               dev_we,
    input  logic [FIELD_W-1:0] dev_wdata,
    output logic [FIELD_W-1:0] live_q,
    output logic [WORD_W-1:0]  rd_word,
    output logic               hit
);
    localparam int NCH   = csr_pkg::num_chunks(FIELD_W, WORD_W);
    localparam int PAD_W = NCH * WORD_W;
    localparam int LAST  = NCH - 1;
    localparam logic [PAD_W-1:0] KEEP     = {PAD_W{1'b1}} >> (PAD_W - FIELD_W);
    localparam logic [PAD_W-1:0] LOW_MASK = PAD_W'({WORD_W{1'b1}});

    logic [ADDR_W-1:0] off;
    logic [PAD_W-1:0]  live_pad, live_nxt;
    logic [PAD_W-1:0]  shadow_q, shadow_nxt;

    // Offset wraps above NCH for addresses below BASE
    assign off = bus_addr - ADDR_W'(BASE);
    assign hit = (off < ADDR_W'(NCH));

    // Read: chunk 0 carries the most significant word
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NCH; i++) begin
            if (hit && off == ADDR_W'(i))
                rd_word = live_pad[(LAST - i) * WORD_W +: WORD_W];
        end
    end

    // Next value of live storage and shadow hold
    always_comb begin
        live_nxt   = live_pad;
        shadow_nxt = shadow_q;
        if (DEV_WRITE && dev_we)
            live_nxt = PAD_W'(dev_wdata);
        if (bus_we && hit) begin
            for (int i = 0; i < NCH; i++) begin
                if (off == ADDR_W'(i)) begin
                    if (ATOMIC && i != LAST) begin
                        shadow_nxt[(LAST - i) * WORD_W +: WORD_W] = bus_wdata;
                    end else if (ATOMIC) begin
                        live_nxt = (shadow_q & ~LOW_MASK) | PAD_W'(bus_wdata);
                    end else begin
                        live_nxt[(LAST - i) * WORD_W +: WORD_W] = bus_wdata;
                    end
                end
            end
        end
        live_nxt = live_nxt & KEEP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_pad <= PAD_W'(RESET_VAL) & KEEP;
            shadow_q <= '0;
        end else begin
            live_pad <= live_nxt;
            shadow_q <= shadow_nxt;
        end
    end

    assign live_q = live_pad[FIELD_W-1:0];

endmodule

// File: rtl/csr_raw_port.sv
module csr_raw_port #(
    parameter int WORD_W = 8,
    parameter int RAW_W  = 8,
    parameter int ADDR_W = 4,
    parameter int ADDR   = 6
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [RAW_W-1:0]  dev_d,
    output logic              dev_rd,
    output logic [WORD_W-1:0] rd_word,
    output logic              hit
);
    assign hit     = (bus_addr == ADDR_W'(ADDR));
    assign dev_rd  = hit && !bus_we;
    assign rd_word = WORD_W'(dev_d);
endmodule

// File: rtl/csr_bank.sv
module csr_bank #(
    parameter int WORD_W = 8,
    parameter int ADDR_W = 4,
    parameter int CFG_W  = 20,
    parameter int CTL_W  = 12,
    parameter int STAT_W = 8,
    parameter int RAW_W  = 8,
    parameter logic [CFG_W-1:0] CFG_RST = 20'hA5C3E,
    parameter logic [CTL_W-1:0] CTL_RST = 12'h3C1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [CFG_W-1:0]  dev_cfg_q,
    output logic [CTL_W-1:0]  dev_ctl_q,
    input  logic              dev_ctl_we,
    input  logic [CTL_W-1:0]  dev_ctl_d,
    input  logic [STAT_W-1:0] dev_stat_d,
    output logic              dev_raw_rd,
    input  logic [RAW_W-1:0]  dev_raw_d
);
    import csr_pkg::*;

    localparam int CFG_N     = num_chunks(CFG_W, WORD_W);
    localparam int CTL_N     = num_chunks(CTL_W, WORD_W);
    localparam int CFG_BASE  = 0;
    localparam int CTL_BASE  = CFG_BASE + CFG_N;
    localparam int STAT_ADDR = CTL_BASE + CTL_N;
    localparam int RAW_ADDR  = STAT_ADDR + 1;

    logic [WORD_W-1:0] cfg_word, ctl_word, raw_word, stat_word, rd_mux;
    logic              cfg_hit, ctl_hit, raw_hit, stat_hit;
    region_e           region;

    csr_wide_field #(
        .FIELD_W(CFG_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .BASE(CFG_BASE),
        .ATOMIC(1'b1), .DEV_WRITE(1'b0), .RESET_VAL(CFG_RST)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .dev_we(1'b0), .dev_wdata('0),
        .live_q(dev_cfg_q), .rd_word(cfg_word), .hit(cfg_hit)
    );

    csr_wide_field #(
        .FIELD_W(CTL_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .BASE(CTL_BASE),
        .ATOMIC(1'b0), .DEV_WRITE(1'b1), .RESET_VAL(CTL_RST)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .dev_we(dev_ctl_we), .dev_wdata(dev_ctl_d),
        .live_q(dev_ctl_q), .rd_word(ctl_word), .hit(ctl_hit)
    );

    csr_raw_port #(
        .WORD_W(WORD_W), .RAW_W(RAW_W), .ADDR_W(ADDR_W), .ADDR(RAW_ADDR)
    ) u_raw (
        .bus_addr(bus_addr), .bus_we(bus_we), .dev_d(dev_raw_d),
        .dev_rd(dev_raw_rd), .rd_word(raw_word), .hit(raw_hit)
    );

    // Status word: no storage, device value passed straight to the read mux
    assign stat_hit  = (bus_addr == ADDR_W'(STAT_ADDR));
    assign stat_word = WORD_W'(dev_stat_d);

    always_comb begin
        if (cfg_hit)       region = RG_CFG;
        else if (ctl_hit)  region = RG_CTL;
        else if (stat_hit) region = RG_STAT;
        else if (raw_hit)  region = RG_RAW;
        else               region = RG_NONE;
    end

    always_comb begin
        unique case (region)
            RG_CFG:  rd_mux = cfg_word;
            RG_CTL:  rd_mux = ctl_word;
            RG_STAT: rd_mux = stat_word;
            RG_RAW:  rd_mux = raw_word;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk #(
    parameter int WORD_W = 8,
    parameter int ADDR_W = 4,
    parameter int CFG_W  = 20,
    parameter int CTL_W  = 12,
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic [CFG_W-1:0]  dev_cfg_q,
    input logic [CTL_W-1:0]  dev_ctl_q,
    input logic              dev_ctl_we,
    input logic [STAT_W-1:0] dev_stat_d,
    input logic              dev_raw_rd
);
    localparam int CFG_N     = csr_pkg::num_chunks(CFG_W, WORD_W);
    localparam int CTL_N     = csr_pkg::num_chunks(CTL_W, WORD_W);
    localparam int CTL_LAST  = CFG_N + CTL_N - 1;
    localparam int STAT_ADDR = CFG_N + CTL_N;
    localparam int MAP_END   = STAT_ADDR + 2;

    a_r3_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr < ADDR_W'(CFG_N - 1) |=> $stable(dev_cfg_q));

    a_r4_commit_low: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr == ADDR_W'(CFG_N - 1) |=> dev_cfg_q[WORD_W-1:0] == $past(bus_wdata));

    a_r7_bus_wins: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && dev_ctl_we && bus_addr == ADDR_W'(CTL_LAST)
        |=> dev_ctl_q[WORD_W-1:0] == $past(bus_wdata));

    a_r8_status_read: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we && bus_addr == ADDR_W'(STAT_ADDR) |=> bus_rdata == WORD_W'($past(dev_stat_d)));

    a_r9_raw_strobe_read: assert property (@(posedge clk) disable iff (!rst_n)
        dev_raw_rd |-> !bus_we);

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we && bus_addr >= ADDR_W'(MAP_END) |=> bus_rdata == '0);

    a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && !dev_ctl_we && bus_addr >= ADDR_W'(MAP_END)
        |=> $stable(dev_cfg_q) && $stable(dev_ctl_q));

endmodule

bind csr_bank csr_bank_chk #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .CFG_W(CFG_W), .CTL_W(CTL_W), .STAT_W(STAT_W)
) u_chk (.*);

// File: tb/tb_csr_bank.sv
`timescale 1ns/1ps
module tb_csr_bank;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  bus_addr;
    logic        bus_we;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [19:0] dev_cfg_q;
    logic [11:0] dev_ctl_q;
    logic        dev_ctl_we;
    logic [11:0] dev_ctl_d;
    logic [7:0]  dev_stat_d;
    logic        dev_raw_rd;
    logic [7:0]  dev_raw_d;

    int n_chk = 0;
    int n_bad = 0;

    logic [19:0] cfg_m;
    logic [11:0] ctl_m;
    logic [7:0]  sh0_m, sh1_m;

    csr_bank dut (.*);

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [3:0] a, input logic [7:0] st, input logic [7:0] rw);
        case (a)
            4'd0: return {4'b0, cfg_m[19:16]};
            4'd1: return cfg_m[15:8];
            4'd2: return cfg_m[7:0];
            4'd3: return {4'b0, ctl_m[11:8]};
            4'd4: return ctl_m[7:0];
            4'd5: return st;
            4'd6: return rw;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] a);
        case (a)
            4'd0, 4'd1: return "R3";
            4'd2:       return "R4";
            4'd3, 4'd4: return "R5";
            4'd5:       return "R8";
            4'd6:       return "R9";
            default:    return "R10";
        endcase
    endfunction

    // One bus cycle, optionally with a device write to control
    task automatic op(input string tag, input logic we, input logic [3:0] a, input logic [7:0] d,
                      input logic dwe, input logic [11:0] dd, input logic [7:0] st, input logic [7:0] rw);
        logic [7:0] e;
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d;
        dev_ctl_we = dwe; dev_ctl_d = dd; dev_stat_d = st; dev_raw_d = rw;
        e = exp_read(a, st, rw);
        #1;
        chk({tag, " R9 strobe"}, 32'(dev_raw_rd), 32'(a == 4'd6 && !we));
        @(posedge clk);
        if (dwe) ctl_m = dd;
        if (we) begin
            case (a)
                4'd0: sh0_m = d;
                4'd1: sh1_m = d;
                4'd2: cfg_m = {sh0_m[3:0], sh1_m, d};
                4'd3: ctl_m[11:8] = d[3:0];
                4'd4: ctl_m[7:0] = d;
                default: ;
            endcase
        end
        #1;
        if (!we) chk({tag, " R11 read"}, 32'(bus_rdata), 32'(e));
        chk({tag, " cfg"}, 32'(dev_cfg_q), 32'(cfg_m));
        chk({tag, " ctl"}, 32'(dev_ctl_q), 32'(ctl_m));
    endtask

    task automatic rd(input string tag, input logic [3:0] a);
        op(tag, 1'b0, a, 8'h00, 1'b0, 12'h000, 8'h5A, 8'hC7);
    endtask

    task automatic wr(input string tag, input logic [3:0] a, input logic [7:0] d);
        op(tag, 1'b1, a, d, 1'b0, 12'h000, 8'h5A, 8'hC7);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        dev_ctl_we = 1'b0; dev_ctl_d = '0; dev_stat_d = '0; dev_raw_d = '0;
        cfg_m = 20'hA5C3E; ctl_m = 12'h3C1; sh0_m = '0; sh1_m = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 cfg reset", 32'(dev_cfg_q), 32'h000A5C3E);
        chk("R1 ctl reset", 32'(dev_ctl_q), 32'h000003C1);
        // R1 / R2: reset image through the bus, MSB word first
        rd("R1 R2 a0", 4'd0);
        rd("R1 R2 a1", 4'd1);
        rd("R1 R2 a2", 4'd2);
        rd("R1 R2 a3", 4'd3);
        rd("R1 R2 a4", 4'd4);
        // R3 / R4 / R6: atomic sequence with padding bits set
        wr("R3 R6 hold a0", 4'd0, 8'hFF);
        wr("R3 hold a1", 4'd1, 8'h12);
        chk("R3 still reset", 32'(dev_cfg_q), 32'h000A5C3E);
        wr("R4 commit a2", 4'd2, 8'h34);
        chk("R4 whole value", 32'(dev_cfg_q), 32'h000F1234);
        rd("R6 pad zero", 4'd0);
        // R4: a second commit reuses the held shadows
        wr("R4 recommit", 4'd2, 8'h9E);
        chk("R4 recommit val", 32'(dev_cfg_q), 32'h000F129E);
        // R5 / R6: non-atomic chunk writes
        wr("R5 low", 4'd4, 8'hAA);
        wr("R5 R6 high", 4'd3, 8'hF6);
        chk("R5 R6 ctl", 32'(dev_ctl_q), 32'h000006AA);
        // R7: device write alone, then a collision
        op("R7 dev only", 1'b0, 4'd9, 8'h00, 1'b1, 12'h123, 8'h00, 8'h00);
        op("R7 collide", 1'b1, 4'd3, 8'h05, 1'b1, 12'hFFF, 8'h00, 8'h00);
        chk("R7 bus wins", 32'(dev_ctl_q), 32'h000005FF);
        // R8 / R9 / R10
        op("R8 status", 1'b0, 4'd5, 8'h00, 1'b0, 12'h0, 8'hA7, 8'h00);
        op("R9 raw read", 1'b0, 4'd6, 8'h00, 1'b0, 12'h0, 8'h00, 8'h3C);
        op("R9 raw write", 1'b1, 4'd6, 8'h77, 1'b0, 12'h0, 8'h00, 8'h3C);
        rd("R10 unmapped read", 4'd9);
        wr("R10 unmapped write", 4'd12, 8'hFF);
        rd("R10 top addr", 4'd15);
        // R11: back-to-back reads of different words
        rd("R11 b2b a1", 4'd1);
        rd("R11 b2b a2", 4'd2);
        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] a;
            a = 4'($urandom_range(0, 10));
            op(req_of(a), 1'($urandom_range(0, 1)), a, 8'($urandom),
               ($urandom_range(0, 7) == 0), 12'($urandom), 8'($urandom), 8'($urandom));
        end
        @(negedge clk); bus_we = 1'b0; dev_ctl_we = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule